// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the memory side of a CPU's entry into an exception handler. When the core raises a trap, the sequencer captures the status word, the address of the next instruction, the stack pointer and the vector number. It then makes three accesses, one at a time, over a simple memory port. First it reads the handler address from a vector table. Next it pushes the status word onto a stack that grows downward. Last it pushes the return address. It then reports the handler address as the new program counter, together with the final stack pointer. The jump is an ordinary branch with no delay slot. The core loads the reported PC directly and runs no instruction in between.

Trap requests arrive over a valid/ready handshake. `trap_ready` is high whenever the sequencer is idle, and a trap is taken on any rising clock edge where `trap_valid` and `trap_ready` are both high. The memory port follows valid/ready rules from the sequencer's side. `mem_req` acts as valid and `mem_ready` is the memory's back-pressure. Once raised, the request and its address, direction and write data stay unchanged until the memory returns ready. An access completes on the edge where both are high. On a read, `mem_rdata` is sampled on that same edge. The memory may hold ready low for any number of cycles. Instruction fetch and pipeline flushing belong to other blocks.

Top module: `exc_entry_seq`

## Requirements
- R1: `trap_ready` is high exactly when the sequencer is idle. A trap is accepted on a rising edge where `trap_valid` and `trap_ready` are both high, and `vec_num`, `cur_sr`, `next_pc` and `cur_sp` are captured on that edge.
- R2: The first access after acceptance is a read (`mem_we` = 0) at address VEC_BASE + 4 × vector number, with the default 32-bit word. The word returned is kept as the handler address.
- R3: The second access is a write (`mem_we` = 1) of the captured status word to address SP − 4, where SP is the captured stack pointer.
- R4: The third access is a write of the captured next-instruction address to address SP − 8.
- R5: `mem_req` is high only while an access is pending. While `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values and the sequence does not advance. Each access takes one cycle plus the number of cycles ready stays low.
- R6: `done` is a one-cycle pulse in the cycle after the handshake of the third access. In that cycle `new_pc` holds the fetched handler address and `new_sp` holds SP − 8, with modulo 2^32 wrap. Both outputs keep these values until the next `done`.
- R7: `busy` is high from the cycle after acceptance through the cycle of the third handshake. While busy, `trap_valid` and any change on the trap inputs have no effect on the accesses or results.
- R8: While `rst_n` is low, and in the first cycle after it goes high, `busy`, `done` and `mem_req` are 0, `trap_ready` is 1, and `new_pc` and `new_sp` are 0.
- R9: In the `done` cycle the sequencer is already idle, so a trap held valid is accepted on that edge. Its vector read starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Sequencer idle, trap can be taken |
| vec_num | input | VEC_W | Vector number of the trap |
| cur_sr | input | XLEN | Status word to save |
| next_pc | input | XLEN | Address of the next instruction, saved as return address |
| cur_sp | input | XLEN | Stack pointer before entry |
| mem_req | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory accepts or completes the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, sampled on the read's handshake edge |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | XLEN | Handler address to load into the PC |
| new_sp | output | XLEN | Stack pointer after both pushes |

## Verification
Several properties are checked on every cycle. A stalled request keeps its address, direction and data unchanged. The first access after a trap is a read at the vector slot of the captured number. `done` never lasts two cycles, and it always carries the captured stack pointer minus eight. A trap is never accepted while busy, and the sequencer is idle in every `done` cycle. Other behaviour shows only in the bench scenarios. These cover the exact order and data of the two pushes and the handler value that reaches `new_pc`. They also show that new trap inputs during a sequence are ignored, how the timing behaves under different memory wait patterns, that a trap held valid is accepted in the `done` cycle, and that the stack pointer wraps around zero.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_SR   = 2'd2,
    ST_PC   = 2'd3
  } exc_state_e;

endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
  parameter int XLEN = 32,
  parameter int VEC_W = 8,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input  logic [VEC_W-1:0] vec,
  output logic [XLEN-1:0]  addr
);
  localparam int WORD_BYTES = XLEN / 8;
  localparam bit POW2 = (WORD_BYTES & (WORD_BYTES - 1)) == 0;
  localparam int SHIFT = $clog2(WORD_BYTES);

  logic [XLEN-1:0] vec_ext;
  assign vec_ext = XLEN'(vec);

  generate
    if (POW2) begin : g_shift
      assign addr = VEC_BASE + (vec_ext << SHIFT);
    end else begin : g_mul
      assign addr = VEC_BASE + vec_ext * XLEN'(WORD_BYTES);
    end
  endgenerate
endmodule

// File: rtl/exc_stack_ptr.sv
module exc_stack_ptr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] load_val,
  input  logic            dec,
  output logic [XLEN-1:0] sp
);
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= '0;
    else if (load) sp <= load_val;
    else if (dec)  sp <= sp - STEP;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_valid,
  input  logic       mem_ready,
  output exc_state_e state,
  output logic       idle,
  output logic       accept,
  output logic       vec_hs,
  output logic       sp_dec,
  output logic       fin
);
  exc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (trap_valid) nxt = ST_VEC;
      ST_VEC:  if (mem_ready)  nxt = ST_SR;
      ST_SR:   if (mem_ready)  nxt = ST_PC;
      ST_PC:   if (mem_ready)  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign idle   = (state == ST_IDLE);
  assign accept = idle && trap_valid;
  assign vec_hs = (state == ST_VEC) && mem_ready;
  // pre-decrement ahead of each push: after the vector read and after the SR push
  assign sp_dec = ((state == ST_VEC) || (state == ST_SR)) && mem_ready;
  assign fin    = (state == ST_PC) && mem_ready;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VEC_W = 8,
  parameter logic [XLEN-1:0] VEC_BASE = 'h400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_valid,
  output logic             trap_ready,
  input  logic [VEC_W-1:0] vec_num,
  input  logic [XLEN-1:0]  cur_sr,
  input  logic [XLEN-1:0]  next_pc,
  input  logic [XLEN-1:0]  cur_sp,
  output logic             mem_req,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  new_sp
);
  exc_state_e      state;
  logic            idle, accept, vec_hs, sp_dec, fin;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0] sr_q, pc_q, handler_q, sp_w, vec_addr;

  exc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .mem_ready(mem_ready),
    .state(state), .idle(idle), .accept(accept), .vec_hs(vec_hs),
    .sp_dec(sp_dec), .fin(fin)
  );

  exc_stack_ptr #(.XLEN(XLEN)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cur_sp),
    .dec(sp_dec), .sp(sp_w)
  );

  exc_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
    .vec(vec_q), .addr(vec_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q     <= '0;
      sr_q      <= '0;
      pc_q      <= '0;
      handler_q <= '0;
    end else begin
      if (accept) begin
        vec_q <= vec_num;
        sr_q  <= cur_sr;
        pc_q  <= next_pc;
      end
      if (vec_hs) handler_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      new_pc <= '0;
      new_sp <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        new_pc <= handler_q;
        new_sp <= sp_w;
      end
    end
  end

  always_comb begin
    mem_addr  = sp_w;
    mem_wdata = '0;
    unique case (state)
      ST_VEC:  mem_addr  = vec_addr;
      ST_SR:   mem_wdata = sr_q;
      ST_PC:   mem_wdata = pc_q;
      default: mem_wdata = '0;
    endcase
  end

  assign trap_ready = idle;
  assign busy       = !idle;
  assign mem_req    = !idle;
  assign mem_we     = (state == ST_SR) || (state == ST_PC);
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 32,
  parameter int VEC_W = 8,
  parameter logic [XLEN-1:0] VEC_BASE = 'h400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trap_valid,
  input logic             trap_ready,
  input logic [VEC_W-1:0] vec_num,
  input logic [XLEN-1:0]  cur_sp,
  input logic             mem_req,
  input logic             mem_ready,
  input logic             mem_we,
  input logic [XLEN-1:0]  mem_addr,
  input logic [XLEN-1:0]  mem_wdata,
  input logic             busy,
  input logic             done,
  input logic [XLEN-1:0]  new_sp
);
  localparam logic [XLEN-1:0] WB = XLEN'(XLEN / 8);

  logic [VEC_W-1:0] c_vec;
  logic [XLEN-1:0]  c_sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_vec <= '0;
      c_sp  <= '0;
    end else if (trap_valid && trap_ready) begin
      c_vec <= vec_num;
      c_sp  <= cur_sp;
    end
  end

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !mem_req && trap_ready));

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && !mem_we));

  assert_vec_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == VEC_BASE + XLEN'(c_vec) * WB));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_sp == c_sp - WB - WB));

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trap_ready);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trap_ready && !busy));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
  .vec_num(vec_num), .cur_sp(cur_sp), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
  .done(done), .new_sp(new_sp)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam logic [31:0] VBASE = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic        trap_ready;
  logic [7:0]  vec_num = '0;
  logic [31:0] cur_sr = '0, next_pc = '0, cur_sp = '0;
  logic        mem_req, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done;
  logic [31:0] new_pc, new_sp;

  always #5 clk = ~clk;

  // vector table contents: a fixed function of the address
  assign mem_rdata = 32'h8000_0000 ^ {mem_addr[27:0], 4'h6};

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .vec_num(vec_num), .cur_sr(cur_sr), .next_pc(next_pc), .cur_sp(cur_sp),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .new_pc(new_pc), .new_sp(new_sp)
  );

  int n_chk = 0, n_fail = 0, acc_cnt = 0, wait_cfg = 0, wcnt = 0;
  bit hs = 0;
  int          m_step = 0;
  logic [31:0] m_sp = '0, m_sr = '0, m_pc = '0, m_vaddr = '0, m_hnd = '0, m_npc = '0, m_nsp = '0;
  bit          m_done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_done = 0; m_npc = '0; m_nsp = '0; hs = 0;
    end else begin
      m_done = 0;
      hs = (m_step != 0) && mem_ready;
      case (m_step)
        0: if (trap_valid) begin
             m_vaddr = VBASE + 32'(vec_num) * 4;
             m_sr = cur_sr; m_pc = next_pc; m_sp = cur_sp;
             acc_cnt++; m_step = 1;
           end
        1: if (mem_ready) begin m_hnd = mem_rdata; m_sp = m_sp - 4; m_step = 2; end
        2: if (mem_ready) begin m_sp = m_sp - 4; m_step = 3; end
        3: if (mem_ready) begin m_npc = m_hnd; m_nsp = m_sp; m_done = 1; m_step = 0; end
        default: m_step = 0;
      endcase
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R8", "busy in reset", 32'(busy), 0);
      chk("R8", "mem_req in reset", 32'(mem_req), 0);
      chk("R8", "new_pc in reset", new_pc, 0);
    end else begin
      chk("R1", "trap_ready", 32'(trap_ready), 32'(m_step == 0));
      chk("R7", "busy", 32'(busy), 32'(m_step != 0));
      chk("R5", "mem_req", 32'(mem_req), 32'(m_step != 0));
      chk("R6", "done", 32'(done), 32'(m_done));
      chk("R6", "new_pc", new_pc, m_npc);
      chk("R6", "new_sp", new_sp, m_nsp);
      if (m_done) chk("R9", "trap_ready in done cycle", 32'(trap_ready), 1);
      case (m_step)
        1: begin chk("R2", "vec read we", 32'(mem_we), 0); chk("R2", "vec addr", mem_addr, m_vaddr); end
        2: begin chk("R3", "sr push we", 32'(mem_we), 1); chk("R3", "sr push addr", mem_addr, m_sp);
                 chk("R3", "sr push data", mem_wdata, m_sr); end
        3: begin chk("R4", "pc push we", 32'(mem_we), 1); chk("R4", "pc push addr", mem_addr, m_sp);
                 chk("R4", "pc push data", mem_wdata, m_pc); end
        default: ;
      endcase
    end
  end

  // memory ready driver with configurable wait cycles
  always @(negedge clk) begin
    if (!mem_req || hs) wcnt = wait_cfg;
    if (mem_req && wcnt == 0) mem_ready = 1'b1;
    else begin
      mem_ready = 1'b0;
      if (mem_req) wcnt--;
    end
  end

  task automatic set_trap(input logic [7:0] v, input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] sp);
    vec_num = v; cur_sr = sr; next_pc = pc; cur_sp = sp; trap_valid = 1'b1;
  endtask

  task automatic wait_accept();
    int a = acc_cnt;
    while (acc_cnt == a) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_step != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R4 R6: basic entry, no wait states
    wait_cfg = 0;
    set_trap(8'd5, 32'h0000_00F0, 32'h1000_0104, 32'h2000_0000);
    wait_accept(); trap_valid = 1'b0; wait_idle();
    // R5: memory stalls three cycles per access
    wait_cfg = 3;
    set_trap(8'd0, 32'hA5A5_0001, 32'h0000_8888, 32'h0001_0010);
    wait_accept(); trap_valid = 1'b0; wait_idle();
    // highest vector, stack down to zero
    wait_cfg = 1;
    set_trap(8'd255, 32'h0000_0007, 32'hDEAD_BEE0, 32'h0000_0008);
    wait_accept(); trap_valid = 1'b0; wait_idle();
    // R7: new trap inputs while busy are ignored
    wait_cfg = 2;
    set_trap(8'd9, 32'h1111_2222, 32'h3333_4444, 32'h0000_4000);
    wait_accept();
    set_trap(8'd77, 32'hFFFF_FFFF, 32'h0BAD_0BAD, 32'h7000_0000);
    repeat (3) @(negedge clk);
    trap_valid = 1'b0; wait_idle();
    // R9: back-to-back traps, second accepted in the done cycle
    wait_cfg = 0;
    set_trap(8'd3, 32'h0000_0101, 32'h0000_2000, 32'h0000_0800);
    wait_accept();
    set_trap(8'd4, 32'h0000_0202, 32'h0000_3000, 32'h0000_0900);
    wait_accept(); trap_valid = 1'b0; wait_idle();
    // R6: stack pointer wraps below zero
    wait_cfg = 1;
    set_trap(8'd17, 32'h0000_0033, 32'h4000_0000, 32'h0000_0004);
    wait_accept(); trap_valid = 1'b0; wait_idle();
    finish_run();
  end
endmodule